// File: doc/BRIEF.md
# Condition Evaluation and Flag Update Unit

This unit sits at the execute stage of a 32-bit processor pipeline. Every instruction there carries a 4-bit condition code in its top bits, and this unit tests that code against the four held status flags: negative, zero, carry and overflow. When the test passes, the unit raises an execute enable. When it fails, the unit raises a bubble signal for that cycle instead. A suppressed instruction still takes its execute slot, but it changes nothing.

The same unit owns the flag register. For each executed instruction it receives the ALU result and the side outputs that go with it: ALU carry, shifter carry and ALU overflow. It also receives the operation class and the set-flags bit. From these it forms the next flag values. Compare operations always write the flags. Logical and arithmetic operations write them only when the set-flags bit is high. A new flag value can be seen at the output one clock after the instruction that wrote it, and the next instruction is already predicated on it.

Top module: `cond_flag_unit`

## Requirements
- R1: Condition codes come from instr_word[31:28]. Codes 0..7 test a single flag: 0 passes if Z=1, 1 if Z=0, 2 if C=1, 3 if C=0, 4 if N=1, 5 if N=0, 6 if V=1, 7 if V=0.
- R2: Codes 8..13 test combined flags: 8 passes if C=1 and Z=0, 9 is the inverse of 8, 10 passes if N==V, 11 if N!=V, 12 if Z=0 and N==V, 13 is the inverse of 12.
- R3: Code 14 always passes and code 15 never passes, whatever the flags.
- R4: exec_en equals instr_valid AND pass, and bubble equals instr_valid AND NOT pass, both in the same cycle. With instr_valid low, both are low.
- R5: An instruction whose condition fails leaves flags_nzcv unchanged.
- R6: A passing instruction of the logical class (op_class=0) or the arithmetic class (op_class=1) with s_bit=0 leaves flags_nzcv unchanged. A compare (op_class=2) writes the flags whatever s_bit is.
- R7: On a flag write, N takes alu_result[31], and Z is 1 exactly when all 32 bits of alu_result are zero.
- R8: On a flag write by the arithmetic or compare class, C takes alu_carry and V takes alu_ovf.
- R9: On a flag write by the logical class, C takes shift_carry and V keeps its previous value.
- R10: After reset flags_nzcv is 0000. The output bit order is [3]=N, [2]=Z, [1]=C, [0]=V. op_class=3 never writes the flags.
- R11: A flag write shows on flags_nzcv after the next rising clock edge. The instruction in the following cycle is evaluated against the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| instr_valid | input | 1 | An instruction occupies the execute slot this cycle |
| instr_word | input | 32 | Instruction; bits 31:28 hold the condition code |
| op_class | input | 2 | 0 logical, 1 arithmetic, 2 compare, 3 no flag effect |
| s_bit | input | 1 | Set-flags request of the instruction |
| alu_result | input | 32 | ALU result for this instruction |
| alu_carry | input | 1 | Carry out of bit 31 of the ALU (no-borrow for subtracts) |
| shift_carry | input | 1 | Carry out of the operand shifter |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| exec_en | output | 1 | Instruction executes |
| bubble | output | 1 | Instruction is suppressed and takes one idle execute cycle |
| flags_nzcv | output | 4 | Held flags, {N,Z,C,V} |

## Verification
The hardest conditions to reach are the combined ones: signed greater-than and less-or-equal, and unsigned higher and lower-or-same. Each needs a particular mix of all four flags at once. The flags can only be set by earlier flag-writing instructions whose results were just right. The stimulus therefore keeps a steady stream of random flag-writing instructions running, and it makes the all-zero and sign-bit results much more likely than chance would. Between those, it runs directed sequences that set each flag pattern and then try every condition code against it back to back.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  localparam int COND_W = 4;

  typedef enum logic [1:0] {
    OPC_LOGIC = 2'd0,
    OPC_ARITH = 2'd1,
    OPC_CMP   = 2'd2,
    OPC_NONE  = 2'd3
  } opclass_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [COND_W-1:0] {
    CC_ZSET = 4'd0,  CC_ZCLR = 4'd1,  CC_CSET = 4'd2,  CC_CCLR = 4'd3,
    CC_NSET = 4'd4,  CC_NCLR = 4'd5,  CC_VSET = 4'd6,  CC_VCLR = 4'd7,
    CC_UHI  = 4'd8,  CC_ULS  = 4'd9,  CC_SGE  = 4'd10, CC_SLT  = 4'd11,
    CC_SGT  = 4'd12, CC_SLE  = 4'd13, CC_ANY  = 4'd14, CC_NONE = 4'd15
  } ccode_e;

endpackage

// File: rtl/cfu_rst_sync.sv
module cfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  nzcv_t             flags,
  output logic              pass
);
  ccode_e cc;
  logic   sgn_eq;
  logic   base;

  assign cc     = ccode_e'(code);
  assign sgn_eq = (flags.n == flags.v);

  // Even/odd pairs are complements for codes 0..13; the base test is
  // selected by code[3:1] and code[0] inverts it.
  always_comb begin
    unique case (code[3:1])
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = sgn_eq;
      3'd6:    base = ~flags.z & sgn_eq;
      default: base = 1'b1;
    endcase
  end

  always_comb begin
    if (cc == CC_ANY)       pass = 1'b1;
    else if (cc == CC_NONE) pass = 1'b0;
    else                    pass = base ^ code[0];
  end
endmodule

// File: rtl/cfu_flag_calc.sv
module cfu_flag_calc
  import cfu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              alu_c,
  input  logic              sh_c,
  input  logic              alu_v,
  input  opclass_e          cls,
  input  nzcv_t             cur,
  output nzcv_t             nxt
);
  localparam int NCHUNK = (DATA_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W  = NCHUNK * CHUNK_W;

  logic [PAD_W-1:0]  padded;
  logic [NCHUNK-1:0] chunk_any;
  logic              is_zero;

  assign padded = PAD_W'(result);

  // Two-level zero detect: OR each chunk, then NOR the chunk flags.
  for (genvar g = 0; g < NCHUNK; g++) begin : g_zchunk
    assign chunk_any[g] = |padded[g*CHUNK_W +: CHUNK_W];
  end

  assign is_zero = ~|chunk_any;

  always_comb begin
    nxt.n = result[DATA_W-1];
    nxt.z = is_zero;
    unique case (cls)
      OPC_LOGIC: begin
        nxt.c = sh_c;
        nxt.v = cur.v;
      end
      OPC_ARITH, OPC_CMP: begin
        nxt.c = alu_c;
        nxt.v = alu_v;
      end
      default: begin
        nxt.c = cur.c;
        nxt.v = cur.v;
      end
    endcase
  end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
  import cfu_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  srst_n,
  input  logic  wr_en,
  input  nzcv_t d,
  output nzcv_t q
);
  nzcv_t q_r;
  nzcv_t q_nxt;
  logic  load;

  always_comb begin
    load  = wr_en | ~srst_n;
    q_nxt = srst_n ? d : '0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q_r <= '0;
    else if (load) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [1:0]         op_class,
  input  logic               s_bit,
  input  logic [DATA_W-1:0]  alu_result,
  input  logic               alu_carry,
  input  logic               shift_carry,
  input  logic               alu_ovf,
  output logic               exec_en,
  output logic               bubble,
  output logic [3:0]         flags_nzcv
);
  localparam int COND_LSB = INSTR_W - COND_W;

  logic     srst_n;
  opclass_e cls;
  nzcv_t    cur_flags;
  nzcv_t    new_flags;
  logic     cond_pass;
  logic     want_write;
  logic     flag_we;

  cfu_rst_sync #(.STAGES(2)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign cls = opclass_e'(op_class);

  cfu_cond_eval u_cond (
    .code  (instr_word[INSTR_W-1:COND_LSB]),
    .flags (cur_flags),
    .pass  (cond_pass)
  );

  cfu_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .result (alu_result),
    .alu_c  (alu_carry),
    .sh_c   (shift_carry),
    .alu_v  (alu_ovf),
    .cls    (cls),
    .cur    (cur_flags),
    .nxt    (new_flags)
  );

  always_comb begin
    exec_en    = instr_valid & cond_pass & srst_n;
    bubble     = instr_valid & ~cond_pass & srst_n;
    want_write = (cls == OPC_CMP) | (s_bit & (cls != OPC_NONE));
    flag_we    = exec_en & want_write;
  end

  cfu_flag_reg u_flags (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n),
    .wr_en  (flag_we),
    .d      (new_flags),
    .q      (cur_flags)
  );

  assign flags_nzcv = cur_flags;
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [31:0] instr_word,
  input logic [1:0]  op_class,
  input logic        s_bit,
  input logic [31:0] alu_result,
  input logic        alu_carry,
  input logic        shift_carry,
  input logic        alu_ovf,
  input logic        exec_en,
  input logic        bubble,
  input logic [3:0]  flags_nzcv
);
  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && bubble));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!exec_en && !bubble));

  assert_always_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en || bubble) && instr_word[31:28] == 4'd14 |-> exec_en);

  assert_never_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_word[31:28] == 4'd15 |-> !exec_en);

  assert_fail_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> $stable(flags_nzcv));

  assert_nos_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && !s_bit && op_class != 2'd2 |=> $stable(flags_nzcv));

  assert_nz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_class != 2'd3 && (s_bit || op_class == 2'd2)
    |=> flags_nzcv[3] == $past(alu_result[31]) &&
        flags_nzcv[2] == ($past(alu_result) == 32'd0));

  assert_arith_cv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && (op_class == 2'd2 || (op_class == 2'd1 && s_bit))
    |=> flags_nzcv[1] == $past(alu_carry) && flags_nzcv[0] == $past(alu_ovf));

  assert_logic_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_class == 2'd0 |=> $stable(flags_nzcv[0]));

  assert_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && op_class == 2'd3 |=> $stable(flags_nzcv));
endmodule

bind cond_flag_unit cfu_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .op_class    (op_class),
  .s_bit       (s_bit),
  .alu_result  (alu_result),
  .alu_carry   (alu_carry),
  .shift_carry (shift_carry),
  .alu_ovf     (alu_ovf),
  .exec_en     (exec_en),
  .bubble      (bubble),
  .flags_nzcv  (flags_nzcv)
);

// File: tb/tb_cond_flag_unit.sv
module tb_cond_flag_unit;
  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic [1:0]  op_class;
  logic        s_bit;
  logic [31:0] alu_result;
  logic        alu_carry;
  logic        shift_carry;
  logic        alu_ovf;
  logic        exec_en;
  logic        bubble;
  logic [3:0]  flags_nzcv;

  int unsigned n_chk;
  int unsigned n_bad;
  logic [3:0]  mflags;   // bench model {N,Z,C,V}

  cond_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .op_class(op_class), .s_bit(s_bit), .alu_result(alu_result),
    .alu_carry(alu_carry), .shift_carry(shift_carry), .alu_ovf(alu_ovf),
    .exec_en(exec_en), .bubble(bubble), .flags_nzcv(flags_nzcv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic cond_ok(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] cc, input logic s,
                       input logic [1:0] cls, input logic [31:0] res,
                       input logic ac, input logic sc, input logic ov);
    logic       pass;
    logic       wr;
    logic [3:0] nxt;
    string      ctag;
    @(negedge clk);
    instr_valid = v;
    instr_word  = {cc, 28'($urandom())};
    s_bit       = s;
    op_class    = cls;
    alu_result  = res;
    alu_carry   = ac;
    shift_carry = sc;
    alu_ovf     = ov;
    #1;
    // R11: the condition is evaluated against the flags written previously
    pass = cond_ok(cc, mflags);
    ctag = (cc < 4'd8) ? "R1" : (cc < 4'd14) ? "R2" : "R3";
    if (!v) ctag = "R4";
    check(exec_en == (v && pass), ctag, "exec_en", 32'(exec_en), 32'(v && pass));
    check(bubble == (v && !pass), "R4", "bubble", 32'(bubble), 32'(v && !pass));
    wr  = v && pass && cls != 2'd3 && (s || cls == 2'd2);
    nxt = mflags;
    if (wr) begin
      nxt[3] = res[31];
      nxt[2] = (res == 32'd0);
      if (cls == 2'd0) nxt[1] = sc;
      else begin
        nxt[1] = ac;
        nxt[0] = ov;
      end
    end
    @(posedge clk);
    #1;
    mflags = nxt;
    if (!v || !pass) begin
      check(flags_nzcv == mflags, "R5", "flags after suppressed/idle",
            32'(flags_nzcv), 32'(mflags));
    end else if (cls == 2'd3) begin
      check(flags_nzcv == mflags, "R10", "flags after class 3",
            32'(flags_nzcv), 32'(mflags));
    end else if (!wr) begin
      check(flags_nzcv == mflags, "R6", "flags without S",
            32'(flags_nzcv), 32'(mflags));
    end else begin
      check(flags_nzcv[3:2] == mflags[3:2], "R7", "N,Z",
            32'(flags_nzcv[3:2]), 32'(mflags[3:2]));
      if (cls == 2'd0)
        check(flags_nzcv[1:0] == mflags[1:0], "R9", "C,V logical",
              32'(flags_nzcv[1:0]), 32'(mflags[1:0]));
      else
        check(flags_nzcv[1:0] == mflags[1:0], "R8", "C,V arith",
              32'(flags_nzcv[1:0]), 32'(mflags[1:0]));
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'hC0DE_5EED);
    n_chk = 0; n_bad = 0; mflags = 4'b0000;
    instr_valid = 0; instr_word = 0; op_class = 0; s_bit = 0;
    alu_result = 0; alu_carry = 0; shift_carry = 0; alu_ovf = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flags_nzcv == 4'b0000, "R10", "flags after reset", 32'(flags_nzcv), 0);
    check(!exec_en && !bubble, "R4", "outputs idle", 32'({exec_en, bubble}), 0);

    // Directed: zero result arithmetic write, then every code back to back (R11)
    apply(1, 4'd14, 1, 2'd1, 32'd0, 1, 1, 0);
    for (int k = 0; k < 16; k++) apply(1, 4'(k), 0, 2'd1, 32'h5, 0, 0, 0);
    // Negative with overflow: N=1 V=1 -> GE/GT true
    apply(1, 4'd14, 0, 2'd2, 32'h8000_0000, 0, 0, 1);
    for (int k = 0; k < 16; k++) apply(1, 4'(k), 0, 2'd0, 32'h1, 0, 0, 0);
    // Logical write keeps V, takes shifter carry (R9)
    apply(1, 4'd14, 1, 2'd0, 32'h8000_0001, 0, 1, 0);
    // Class 3 with S set does not write (R10)
    apply(1, 4'd14, 1, 2'd3, 32'd0, 1, 1, 1);
    // Never code with a compare (R3, R5)
    apply(1, 4'd15, 1, 2'd2, 32'd0, 1, 1, 1);
    // Idle slot with compare fields (R4)
    apply(0, 4'd14, 1, 2'd2, 32'd0, 1, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [3:0]  sel;
      sel = 4'($urandom());
      r   = (sel == 0) ? 32'd0 : (sel == 1) ? 32'h8000_0000 : $urandom();
      apply(($urandom() % 8) != 0, 4'($urandom()), 1'($urandom()),
            2'($urandom()), r, 1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    summary();
    $finish;
  end
endmodule